// File: doc/BRIEF.md
# Oscillator Stabilization Wait Counter

This block times how long an external crystal oscillator has been running since it was last started or restarted. A counter runs on the crystal clock itself. As the count passes each of five fixed power-of-two points, a sticky flag sets. The flags form a thermometer code and are presented to the CPU clock domain as a read-only status byte. Software picks one of the five points as the required stabilization time. The counter never runs past that point, and a done signal rises once it is reached.

Every event that stops the oscillator or puts the system to sleep clears the status and restarts the measurement. These events are a reset, a stop-mode entry pulse, and the oscillator-stop control bit being set. The clear starts in the CPU domain and is held on the crystal-domain counter until the crystal side acknowledges it. Time spent before the oscillator delivers edges is never counted.

The first threshold exponent is the parameter `FIRST_EXP`, which defaults to 11. The five thresholds are 2^FIRST_EXP followed by 2^(FIRST_EXP+2) through 2^(FIRST_EXP+5). With the default these are 2^11, 2^13, 2^14, 2^15 and 2^16 crystal cycles.

Top module: `osc_settle_wait`

## Requirements
- R1: The five status flags set only in ascending threshold order. Status bit 4 is set first and bit 0 last, so at any moment bits 4..0 read as ones from bit 4 down, followed by zeros.
- R2: A set flag stays set until a clear event.
- R3: After reset, `status` reads 8'h00 and `wait_done` reads 0. In the cycle after `stop_enter` or `osc_stop` is sampled high, `status` reads 8'h00 and `wait_done` reads 0, and the measurement then restarts from zero.
- R4: `wait_sel` values 0, 1, 2, 3 and 4 cap the count at the 1st, 2nd, 3rd, 4th and 5th threshold respectively. Values 5 to 7 act as 4. No flag above the cap ever sets.
- R5: Bit 4 holds the 2^FIRST_EXP flag. Bits 3, 2, 1 and 0 hold the flags for exponents FIRST_EXP+2, +3, +4 and +5. Bits 7..5 always read 0. A run capped at selection 0 ends at 8'h10, and one capped at selection 2 ends at 8'h1C.
- R6: `status_bit` always equals `status[bit_sel]`. For `bit_sel` 5..7 this is 0.
- R7: `wait_done` rises once the count reaches the selected cap and stays high until a clear event. While `wait_done` is high, status bit 4 is also high.
- R8: While `osc_stop` is held high, `status` stays 8'h00. Counting restarts only on crystal edges after `osc_stop` falls.
- R9: The counter saturates at the cap and never wraps. The final status and done value hold for as long as the oscillator keeps running.
- R10: A flag reads set no earlier than its threshold in crystal cycles after the clear, and no later than that plus a bounded synchronization and handshake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock; all outputs are registered on it |
| xtal_clk | input | 1 | Crystal oscillator clock being measured |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| stop_enter | input | 1 | One-cycle pulse marking entry to stop mode (cpu_clk) |
| osc_stop | input | 1 | Oscillator-stop control bit; holds the measurement cleared while 1 |
| wait_sel | input | 3 | Stabilization time select; change only while cleared |
| bit_sel | input | 3 | Bit index for the single-bit status read |
| status | output | 8 | Thermometer status byte, bits 7..5 zero |
| status_bit | output | 1 | Selected bit of the status byte |
| wait_done | output | 1 | Selected stabilization time reached |

## Verification
A counter that loses a flag or sets one too early shows at once as a status byte that breaks the ones-then-zeros pattern, or that falls outside the window the bench model predicts from its own crystal edge count. Such an error is visible within the synchronizer delay of a few CPU cycles. A wrong cap, or a counter that wraps, appears as an extra flag or a dropped `wait_done` a few thousand crystal cycles into a run. A stuck clear handshake shows either as a status byte that stays zero past its lower bound, or as stale flags in the cycle after a stop event.

// File: rtl/osw_pkg.sv
package osw_pkg;

   localparam int unsigned NUM_FLAGS = 5;
   localparam int unsigned STATUS_W  = 8;

   // exponent of flag i: the first point, then a gap of one, then consecutive
   function automatic int unsigned flag_exp(input int unsigned first, input int unsigned i);
      return (i == 0) ? first : first + 1 + i;
   endfunction

   // selection to cap index; out-of-range codes mean the longest wait
   function automatic int unsigned sel_to_idx(input logic [2:0] sel);
      return (sel > 3'd4) ? 4 : int'(sel);
   endfunction

   typedef enum logic [1:0] {
      CLR_IDLE  = 2'd0,
      CLR_HOLD  = 2'd1,
      CLR_DRAIN = 2'd2
   } clr_state_t;

endpackage

// File: rtl/osw_sync.sv
module osw_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osw_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("osw_sync: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/osw_xtal_count.sv
module osw_xtal_count
   import osw_pkg::*;
#(
   parameter int unsigned FIRST_EXP = 11
) (
   input  logic                 xtal_clk,
   input  logic                 rst_n,
   input  logic                 clr_hold,
   input  logic [2:0]           wait_sel,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 done,
   output logic                 clr_ack
);

   localparam int unsigned LAST_EXP = FIRST_EXP + NUM_FLAGS;
   localparam int unsigned CW       = LAST_EXP + 1;

   if (FIRST_EXP < 1 || FIRST_EXP > 26) begin : g_bad_exp
      $error("osw_xtal_count: FIRST_EXP out of range");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] thr [NUM_FLAGS];
   logic [CW-1:0] limit;
   int unsigned   cap_idx;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_thr
      assign thr[i] = CW'(1) << flag_exp(FIRST_EXP, i);
   end

   always_comb begin
      cap_idx = sel_to_idx(wait_sel);
      limit   = thr[cap_idx];
   end

   always_ff @(posedge xtal_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         flags <= '0;
         done  <= 1'b0;
      end else if (clr_hold) begin
         cnt   <= '0;
         flags <= '0;
         done  <= 1'b0;
      end else begin
         if (cnt != limit) cnt <= cnt + 1'b1;
         for (int i = 0; i < NUM_FLAGS; i++) begin
            if (i <= int'(cap_idx) && cnt >= thr[i]) flags[i] <= 1'b1;
         end
         if (cnt == limit) done <= 1'b1;
      end
   end

   always_ff @(posedge xtal_clk or negedge rst_n) begin
      if (!rst_n) clr_ack <= 1'b0;
      else        clr_ack <= clr_hold;
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag_chk
      // R2
      flag_sticky_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
         (flags[i] && !clr_hold) |=> flags[i]);
   end

   // R9
   no_overflow_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
      (cnt != '0 && !clr_hold) |=> (cnt != '0));

   // R7
   done_after_first_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
      done |-> flags[0]);

endmodule

// File: rtl/osw_clr_ctrl.sv
module osw_clr_ctrl
   import osw_pkg::*;
(
   input  logic cpu_clk,
   input  logic rst_n,
   input  logic clr_evt,
   input  logic ack_sync,
   output logic req,
   output logic busy
);

   clr_state_t state, state_nx;
   logic       pending, pending_nx;

   always_comb begin
      state_nx   = state;
      pending_nx = pending;
      unique case (state)
         CLR_IDLE: begin
            if (clr_evt) state_nx = CLR_HOLD;
         end
         CLR_HOLD: begin
            if (ack_sync && !clr_evt) state_nx = CLR_DRAIN;
         end
         CLR_DRAIN: begin
            if (clr_evt) pending_nx = 1'b1;
            if (!ack_sync) begin
               state_nx   = (pending || clr_evt) ? CLR_HOLD : CLR_IDLE;
               pending_nx = 1'b0;
            end
         end
         default: state_nx = CLR_IDLE;
      endcase
   end

   always_ff @(posedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CLR_IDLE;
         pending <= 1'b0;
      end else begin
         state   <= state_nx;
         pending <= pending_nx;
      end
   end

   assign req  = (state == CLR_HOLD);
   assign busy = (state != CLR_IDLE);

   // R3
   hold_until_ack_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (req && !ack_sync) |=> req);

endmodule

// File: rtl/osc_settle_wait.sv
module osc_settle_wait
   import osw_pkg::*;
#(
   parameter int unsigned FIRST_EXP   = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       cpu_clk,
   input  logic       xtal_clk,
   input  logic       rst_n,
   input  logic       stop_enter,
   input  logic       osc_stop,
   input  logic [2:0] wait_sel,
   input  logic [2:0] bit_sel,
   output logic [7:0] status,
   output logic       status_bit,
   output logic       wait_done
);

   localparam int unsigned XW = NUM_FLAGS + 1;

   if (STATUS_W != 8) begin : g_bad_status
      $error("osc_settle_wait: status byte must be 8 bits");
   end

   logic                 clr_evt;
   logic                 req, busy;
   logic                 req_x, ack_x, ack_c;
   logic [NUM_FLAGS-1:0] flags_x;
   logic                 done_x;
   logic [XW-1:0]        xbus_c;
   logic [NUM_FLAGS-1:0] mapped;
   logic [7:0]           status_r;
   logic                 done_r;

   assign clr_evt = stop_enter | osc_stop;

   osw_clr_ctrl u_ctrl (
      .cpu_clk  (cpu_clk),
      .rst_n    (rst_n),
      .clr_evt  (clr_evt),
      .ack_sync (ack_c),
      .req      (req),
      .busy     (busy)
   );

   osw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk (xtal_clk), .rst_n (rst_n), .d (req), .q (req_x)
   );

   osw_xtal_count #(.FIRST_EXP(FIRST_EXP)) u_count (
      .xtal_clk (xtal_clk),
      .rst_n    (rst_n),
      .clr_hold (req_x),
      .wait_sel (wait_sel),
      .flags    (flags_x),
      .done     (done_x),
      .clr_ack  (ack_x)
   );

   osw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk (cpu_clk), .rst_n (rst_n), .d (ack_x), .q (ack_c)
   );

   osw_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_flag_sync (
      .clk (cpu_clk), .rst_n (rst_n), .d ({done_x, flags_x}), .q (xbus_c)
   );

   // lowest threshold lands on the highest used bit
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_map
      assign mapped[NUM_FLAGS-1-i] = xbus_c[i];
   end

   always_ff @(posedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         status_r <= '0;
         done_r   <= 1'b0;
      end else if (clr_evt || busy) begin
         status_r <= '0;
         done_r   <= 1'b0;
      end else begin
         status_r <= {{(STATUS_W-NUM_FLAGS){1'b0}}, mapped};
         done_r   <= xbus_c[NUM_FLAGS];
      end
   end

   assign status     = status_r;
   assign status_bit = status_r[bit_sel];
   assign wait_done  = done_r;

   // R1
   thermometer_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (status[3:0] & ~status[4:1]) == 4'b0);

   // R3
   clear_zero_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      clr_evt |=> (status == 8'h00 && !wait_done));

   // R7
   done_implies_flag_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      wait_done |-> status[4]);

endmodule

// File: tb/osc_settle_wait_test.sv
`timescale 1ns/1ps
module osc_settle_wait_test;

   localparam int unsigned FE    = 5;   // thresholds 32,128,256,512,1024
   localparam int          SLACK = 24;  // crystal edges of handshake/sync delay

   logic       cpu_clk = 0, xtal_clk = 0, rst_n = 0;
   logic       stop_enter = 0, osc_stop = 0;
   logic [2:0] wait_sel = 0, bit_sel = 0;
   logic [7:0] status;
   logic       status_bit, wait_done;

   int total = 0, bad = 0, cycles = 0;
   int xcnt = 0;
   int kick_id = 0, kick_seen = 0;
   bit chk_en = 0, finished = 0;

   always #4 cpu_clk = ~cpu_clk;    // 125 MHz
   always #5 xtal_clk = ~xtal_clk;

   osc_settle_wait #(.FIRST_EXP(FE)) uut (
      .cpu_clk(cpu_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
      .stop_enter(stop_enter), .osc_stop(osc_stop),
      .wait_sel(wait_sel), .bit_sel(bit_sel),
      .status(status), .status_bit(status_bit), .wait_done(wait_done));

   // reference: crystal edges since the last clear event
   always @(posedge xtal_clk) begin
      if (!rst_n || osc_stop || kick_seen != kick_id) xcnt <= 0;
      else xcnt <= xcnt + 1;
      kick_seen <= kick_id;
   end

   function automatic int thr(int i);
      return (i == 0) ? (1 << FE) : (1 << (FE + 1 + i));
   endfunction
   function automatic int cap_of(logic [2:0] s);
      return (s > 4) ? 4 : int'(s);
   endfunction
   function automatic int level(int c);
      int n = 0;
      for (int i = 0; i < 5; i++)
         if (i <= cap_of(wait_sel) && c >= thr(i) + 1) n++;
      return n;
   endfunction
   function automatic logic [7:0] thermo(int n);
      return 8'((((1 << n) - 1) << (5 - n)) & 8'h1F);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference window
   always @(negedge cpu_clk) begin
      cycles++;
      if (chk_en && !finished) begin
         int n, lo, hi;
         n  = $countones(status[4:0]);
         lo = level(xcnt - SLACK);
         hi = level(xcnt);
         check(status == thermo(n), "R1", status, thermo(n));
         check(status[7:5] == 0, "R5", status, status & 8'h1F);
         check(n >= lo && n <= hi, "R10", n, lo);
         check(status_bit == status[bit_sel], "R6", status_bit, status[bit_sel]);
         if (xcnt - SLACK >= thr(cap_of(wait_sel)) + 1)
            check(wait_done == 1, "R7", wait_done, 1);
         if (xcnt < thr(cap_of(wait_sel)) + 1)
            check(wait_done == 0, "R7", wait_done, 0);
      end
   end

   always @(negedge cpu_clk) begin
      if (cycles > 150000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic xwait(int n);
      repeat (n) @(posedge xtal_clk);
      @(negedge cpu_clk);
   endtask

   task automatic stop_pulse();
      chk_en = 0;
      @(negedge cpu_clk);
      stop_enter = 1;
      kick_id++;
      @(negedge cpu_clk);
      stop_enter = 0;
      check(status == 8'h00, "R3 stop", status, 0);
      check(wait_done == 0, "R3 stop done", wait_done, 0);
      repeat (3) @(posedge xtal_clk);
      @(negedge cpu_clk);
      chk_en = 1;
   endtask

   task automatic full_run(logic [2:0] s, logic [7:0] exp_final, string tag);
      chk_en = 0;
      @(negedge cpu_clk);
      wait_sel = s;
      stop_pulse();
      xwait(thr(cap_of(s)) + SLACK + 8);
      check(status == exp_final, tag, status, exp_final);
      check(wait_done == 1, "R7 done", wait_done, 1);
      xwait(1500);
      check(status == exp_final, "R9 hold", status, exp_final);
      check(wait_done == 1, "R9 done hold", wait_done, 1);
   endtask

   initial begin
      repeat (3) @(negedge cpu_clk);
      check(status == 8'h00, "R3 reset", status, 0);
      check(wait_done == 0, "R3 reset done", wait_done, 0);
      rst_n = 1;
      chk_en = 1;

      full_run(3'd0, 8'h10, "R5 sel0");
      for (int b = 0; b < 8; b++) begin
         bit_sel = 3'(b);
         @(negedge cpu_clk);
         check(status_bit == ((b == 4) ? 1'b1 : 1'b0), "R6 bit", status_bit, (b == 4));
      end
      full_run(3'd2, 8'h1C, "R5 sel2");
      full_run(3'd1, 8'h18, "R4 sel1");
      bit_sel = 3'd3;
      full_run(3'd6, 8'h1F, "R4 sel6");
      full_run(3'd4, 8'h1F, "R4 sel4");

      // osc_stop held: stays clear, restarts only after release
      chk_en = 0;
      @(negedge cpu_clk);
      osc_stop = 1;
      @(negedge cpu_clk);
      check(status == 8'h00, "R3 osc", status, 0);
      check(wait_done == 0, "R3 osc done", wait_done, 0);
      chk_en = 1;
      xwait(1500);
      check(status == 8'h00, "R8 held", status, 0);
      check(wait_done == 0, "R8 held done", wait_done, 0);
      wait_sel = 3'd0;
      @(negedge cpu_clk);
      osc_stop = 0;
      xwait(thr(0) - 4);
      check(status == 8'h00, "R8 early", status, 0);
      xwait(SLACK + 12);
      check(status == 8'h10, "R8 restart", status, 8'h10);

      // stop pulse in the middle of a run, sticky flags up to cap
      wait_sel = 3'd3;
      stop_pulse();
      xwait(300);
      stop_pulse();
      xwait(thr(3) + SLACK + 8);
      check(status == 8'h1E, "R2 cap3", status, 8'h1E);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule